// File: doc/BRIEF.md
# Late-Sample Checking Result Register

This block is the output register that sits after a multiplier whose clock period is shorter than its worst-case path. The register samples each result bit twice. The main flop takes the result at the normal clock edge. A shadow copy holds the same result as it stood a little later. That later sample comes in as a second data input, because the delayed clock that produces it is generated outside this block.

When the two samples of a freshly captured result differ, the path did not settle in time. The block then raises one error flag and, on that same edge, overwrites the registered result with the shadow value. It also drops any capture requested on that edge, so the upstream control can replay that operation. The same flag goes to the re-execution control and to the hold logic that tracks how often errors occur.

Top module: `razor_out_reg`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `q` is all zeros and `err` is 0.
- R2: When `cap_en` is 1 at an edge and no correction happens at that edge, `q` shows that edge's `res_main` from then on.
- R3: A captured result whose `res_main` equals its `res_late` never produces `err` = 1.
- R4: A captured result whose main and late values differ in any bit sets `err` to 1 for the cycle after the next edge, which is one cycle after the capture.
- R5: At the edge where `err` rises, `q` is loaded with the late value of the faulty result.
- R6: A capture requested at the correcting edge is discarded. `q` keeps the late value, and that discarded capture can raise no error.
- R7: With `cap_en` at 0, `q` holds its value and no error follows, whatever `res_main` and `res_late` carry.
- R8: A disagreement in any single bit position, from bit 0 to bit 2M-1, is flagged.
- R9: `err` lasts exactly one cycle per faulty capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Normal capture clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_en | input | 1 | A new result is present this cycle |
| res_main | input | 2M | Datapath result at the normal edge |
| res_late | input | 2M | Same result sampled late |
| q | output | 2M | Registered (and corrected) product |
| err | output | 1 | Timing error, one cycle after the faulty capture |

## Verification
The bench builds the block with M = 4, so the register is 8 bits wide. At that width the stimulus table stays readable as hexadecimal values, and a walking single-bit disagreement reaches every bit position, including the LSB and the MSB. The table covers a capture that lands on the correcting edge and its replay one cycle later. Directed steps then cover reset applied while a mismatch is pending.

// File: rtl/razor_pkg.sv
// Package: shared defaults for the late-sample checking register.
// Assumes the product is twice the operand width.
package razor_pkg;
    localparam int unsigned DEF_OPND_W = 8;

    function automatic int unsigned prod_width(input int unsigned opnd_w);
        return 2 * opnd_w;
    endfunction
endpackage

// File: rtl/razor_bit.sv
// One result bit: a main flop and a shadow copy, with a mismatch output.
// Assumes fix and cap are never both acted on (fix wins), and that
// res_late is stable by the time of the capture edge.
module razor_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic cap,
    input  logic fix,
    input  logic d_main,
    input  logic d_late,
    output logic q,
    output logic mis
);
    logic main_r;
    logic shad_r;

    // Capture both samples, or restore the main flop from the shadow on a fix.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_r <= 1'b0;
            shad_r <= 1'b0;
        end else if (fix) begin
            main_r <= shad_r;
        end else if (cap) begin
            main_r <= d_main;
            shad_r <= d_late;
        end
    end

    // Compare the two stored samples.
    always_comb mis = main_r ^ shad_r;

    assign q = main_r;
endmodule

// File: rtl/razor_or_reduce.sv
// Wide OR of the per-bit mismatch flags.
// Assumes the vector is at least one bit wide.
module razor_or_reduce #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] vec,
    output logic         any
);
    // Fold all bits into a single flag.
    always_comb begin
        any = 1'b0;
        for (int i = 0; i < W; i++) begin
            any = any | vec[i];
        end
    end
endmodule

// File: rtl/razor_out_reg.sv
// Result register with late-sample checking and in-place correction.
// The error flag rises one cycle after a faulty capture. On that edge the
// shadow value replaces the main value, and a coinciding capture is dropped
// so that upstream control can replay it.
module razor_out_reg #(
    parameter int unsigned OPND_W = razor_pkg::DEF_OPND_W,
    localparam int unsigned W     = razor_pkg::prod_width(OPND_W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_en,
    input  logic [W-1:0] res_main,
    input  logic [W-1:0] res_late,
    output logic [W-1:0] q,
    output logic         err
);
    logic [W-1:0] bit_mis;
    logic         any_mis;
    logic         pend_r;
    logic         fix;
    logic         cap_go;
    logic         err_r;

    // A correction is due when the last capture disagrees with its shadow.
    assign fix    = pend_r & any_mis;
    assign cap_go = cap_en & ~fix;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            razor_bit u_bit (
                .clk    (clk),
                .rst_n  (rst_n),
                .cap    (cap_go),
                .fix    (fix),
                .d_main (res_main[g]),
                .d_late (res_late[g]),
                .q      (q[g]),
                .mis    (bit_mis[g])
            );
        end
    endgenerate

    razor_or_reduce #(.W(W)) u_or (
        .vec (bit_mis),
        .any (any_mis)
    );

    // Mark that a fresh result sits in the register, and register the error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_r <= 1'b0;
            err_r  <= 1'b0;
        end else begin
            pend_r <= cap_go;
            err_r  <= fix;
        end
    end

    assign err = err_r;
endmodule

// File: rtl/razor_out_reg_chk.sv
// Checker for razor_out_reg, observing its ports only.
module razor_out_reg_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cap_en,
    input logic [W-1:0] res_main,
    input logic [W-1:0] res_late,
    input logic [W-1:0] q,
    input logic         err
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q == '0 && !err)); // R1
    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en ##1 !err |-> q == $past(res_main)); // R2
    AST_MATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && res_main == res_late) |=> ##1 !err); // R3
    AST_CORRECTED: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> q == $past(res_late, 2)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ##1 !err); // R7
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R9
endmodule

bind razor_out_reg razor_out_reg_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .res_main (res_main),
    .res_late (res_late),
    .q        (q),
    .err      (err)
);

// File: tb/razor_out_reg_tb.sv
module razor_out_reg_tb;
    localparam int CLK_PER = 10;
    localparam int OPND_W  = 4;
    localparam int W       = 2 * OPND_W;
    localparam int ROWS    = 15;

    // Row: {cap, main, late, exp_q, exp_err, req}
    typedef struct packed {
        logic         cap;
        logic [W-1:0] dm;
        logic [W-1:0] dl;
        logic [W-1:0] eq;
        logic         ee;
        logic [3:0]   req;
    } row_t;

    localparam row_t TAB [ROWS] = '{
        '{1'b1, 8'h12, 8'h12, 8'h12, 1'b0, 4'd2},  // R2 first capture
        '{1'b1, 8'h34, 8'h34, 8'h34, 1'b0, 4'd3},  // R3 match, no error
        '{1'b0, 8'hAA, 8'h55, 8'h34, 1'b0, 4'd7},  // R7 idle holds
        '{1'b0, 8'hFF, 8'h00, 8'h34, 1'b0, 4'd7},  // R7 idle holds
        '{1'b1, 8'h70, 8'h71, 8'h70, 1'b0, 4'd2},  // faulty capture
        '{1'b0, 8'h00, 8'h00, 8'h71, 1'b1, 4'd5},  // R4 R5 corrected
        '{1'b0, 8'h00, 8'h00, 8'h71, 1'b0, 4'd9},  // R9 one cycle only
        '{1'b1, 8'h80, 8'h00, 8'h80, 1'b0, 4'd2},  // MSB fault captured
        '{1'b1, 8'h5A, 8'h5A, 8'h00, 1'b1, 4'd6},  // R6 capture dropped
        '{1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 4'd6},  // R6 no trace of dropped
        '{1'b1, 8'hC3, 8'hC3, 8'hC3, 1'b0, 4'd2},
        '{1'b1, 8'h3C, 8'h3D, 8'h3C, 1'b0, 4'd2},
        '{1'b1, 8'h11, 8'h11, 8'h3D, 1'b1, 4'd6},  // R6 dropped again
        '{1'b1, 8'h11, 8'h11, 8'h11, 1'b0, 4'd2},  // replay accepted
        '{1'b0, 8'h00, 8'h00, 8'h11, 1'b0, 4'd9}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cap_en = 1'b0;
    logic [W-1:0] res_main = '0;
    logic [W-1:0] res_late = '0;
    logic [W-1:0] q;
    logic         err;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    razor_out_reg #(.OPND_W(OPND_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
        .res_main(res_main), .res_late(res_late), .q(q), .err(err)
    );

    task automatic check(input logic [W-1:0] eq, input logic ee, input int req);
        n_chk++;
        if (q !== eq || err !== ee) begin
            n_bad++;
            $display("FAIL R%0d: q=%h err=%b expected q=%h err=%b", req, q, err, eq, ee);
        end
    endtask

    // Drive on the falling edge, let one rising edge pass, sample on the next fall.
    task automatic step(input logic c, input logic [W-1:0] dm, input logic [W-1:0] dl);
        cap_en = c; res_main = dm; res_late = dl;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        check('0, 1'b0, 1);                       // R1 during reset
        rst_n = 1'b1;
        step(1'b0, '0, '0);
        check('0, 1'b0, 1);                       // R1 after release
        for (int i = 0; i < ROWS; i++) begin
            step(TAB[i].cap, TAB[i].dm, TAB[i].dl);
            check(TAB[i].eq, TAB[i].ee, int'(TAB[i].req));
        end
        // R8: a single differing bit at every position
        for (int b = 0; b < W; b++) begin
            step(1'b1, '0, W'(1) << b);
            check('0, 1'b0, 2);
            step(1'b0, '0, '0);
            check(W'(1) << b, 1'b1, 8);
            step(1'b0, '0, '0);
            check(W'(1) << b, 1'b0, 9);
        end
        // R1: reset while a mismatch is pending
        step(1'b1, 8'hF0, 8'h0F);
        rst_n = 1'b0;
        step(1'b0, '0, '0);
        check('0, 1'b0, 1);
        rst_n = 1'b1;
        step(1'b0, '0, '0);
        check('0, 1'b0, 1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule